// File: doc/BRIEF.md
# Parity Error Concealment and Mute

This block sits on the per-sample output of a digital audio receiver. Each sample arrives with a strobe, a channel index, 24 bits of data, a flag that marks a parity failure on that sample, and a flag that marks the stream as non-PCM. When concealment is enabled and applies to the stream, a short burst of bad samples on a channel is covered by repeating that channel's last good sample. Once the burst grows too long, the channel is muted until a clean sample arrives.

A second function tracks frames. It counts how many frames in a row have arrived with no parity failure. Once that run is long enough, it raises a flag that tells the status logic it may refresh its validity, user, channel-status, non-PCM and compressed-stream detection flags. Parity computation and frame decoding happen upstream.

Top module: `audio_conceal`

## Requirements
- R1: The mode field `mode_i` uses these codes: 2'b00 means no processing and 2'b11 (reserved) does the same. In either code every sample passes unchanged, including samples with a parity error, and `mute_o` stays 0.
- R2: Mode 2'b01 conceals only samples with `non_pcm_i`=0. A sample with `non_pcm_i`=1 passes unchanged with `mute_o`=0.
- R3: Mode 2'b10 conceals samples whether `non_pcm_i` is 0 or 1.
- R4: When `err_en_i`=0, no sample is concealed or muted in any mode. Every sample passes unchanged.
- R5: While concealment applies, the 1st through 8th consecutive parity-error samples on a channel output the last good sample of that channel (0 if none since reset), with `mute_o`=0.
- R6: While concealment applies, the 9th and every later consecutive parity-error sample on a channel outputs all-zero data with `mute_o`=1.
- R7: A sample without a parity error passes unchanged and becomes the held sample of its channel. It clears that channel's error run and sets `mute_o` to 0. A sample that is not concealed also clears the run.
- R8: Held samples and error runs are kept separately for channel 0 and channel 1 (`smp_chan_i`). Samples on one channel never change what the other channel outputs.
- R9: `data_o` and `mute_o` update on the rising clock edge at which `smp_vld_i`=1 is sampled, and hold their value between strobes.
- R10: A frame ends with a channel-1 sample. `refresh_ok_o` is 1 once more than 192 consecutive frames (that is, 193) have ended with no parity-error sample in between. Any parity-error sample, in any mode, drops it to 0 at the next edge and restarts the count.
- R11: After reset, `data_o`=0, `mute_o`=0 and `refresh_ok_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| smp_chan_i | input | 1 | Channel of the sample (1 = frame end) |
| smp_data_i | input | 24 | Sample data |
| par_err_i | input | 1 | Parity error on this sample |
| non_pcm_i | input | 1 | Stream is non-PCM |
| err_en_i | input | 1 | Enables concealment and mute |
| mode_i | input | 2 | Processing mode |
| data_o | output | 24 | Processed sample |
| mute_o | output | 1 | Output sample is muted |
| refresh_ok_o | output | 1 | Status flags may be refreshed |

## Verification
The bench sweeps every mode code, enable value and non-PCM value through the same sequence. Channel 0 takes a run of ten bad samples while channel 1 stays clean. A design off by one in the run limit would mute on the 8th error or conceal the 9th, and a design that shares state between channels would replay the wrong channel's data. The sequence then checks that a single clean sample un-mutes the channel and re-arms the full eight-sample budget, which a design that fails to clear the run would get wrong. The frame counter is probed at exactly 192 and 193 clean frames and right after an error, which exposes a counter that compares with the wrong bound or never restarts.

// File: rtl/conceal_pkg.sv
package conceal_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_PCM = 2'b01,
    MODE_ALL = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  function automatic logic conceal_applies(input logic [1:0] mode, input logic en,
                                           input logic npcm);
    logic r;
    r = 1'b0;
    if (en) begin
      case (mode_e'(mode))
        MODE_PCM: r = !npcm;
        MODE_ALL: r = 1'b1;
        default:  r = 1'b0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/conceal_chan.sv
module conceal_chan #(
  parameter int DATA_W   = 24,
  parameter int HOLD_MAX = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              active_i,
  input  logic              par_err_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_mute_o
);
  localparam int CNT_W = $clog2(HOLD_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(HOLD_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(HOLD_MAX);

  logic [DATA_W-1:0] held_q, held_d;
  logic [CNT_W-1:0]  run_q, run_d;

  always_comb begin
    held_d     = par_err_i ? held_q : data_i;
    res_data_o = data_i;
    res_mute_o = 1'b0;
    run_d      = '0;
    if (active_i && par_err_i) begin
      run_d = (run_q == CNT_SAT) ? run_q : run_q + 1'b1;
      if (run_d > CNT_LIM) begin
        res_data_o = '0;
        res_mute_o = 1'b1;
      end else begin
        res_data_o = held_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      run_q  <= '0;
    end else if (hit_i) begin
      held_q <= held_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int FRAMES = 192,
  parameter int CH_W   = 1,
  parameter int LAST_CH = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            par_err_i,
  output logic            ok_o
);
  localparam int CNT_W = $clog2(FRAMES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(FRAMES);

  logic [CNT_W-1:0] clean_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clean_q <= '0;
    end else if (vld_i) begin
      if (par_err_i)
        clean_q <= '0;
      else if (chan_i == CH_W'(LAST_CH) && clean_q != CNT_SAT)
        clean_q <= clean_q + 1'b1;
    end
  end

  assign ok_o = clean_q > CNT_LIM;
endmodule

// File: rtl/audio_conceal.sv
module audio_conceal
  import conceal_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NUM_CH   = 2,
  parameter int HOLD_MAX = 8,
  parameter int FRAMES   = 192,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [CH_W-1:0]   smp_chan_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              par_err_i,
  input  logic              non_pcm_i,
  input  logic              err_en_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] data_o,
  output logic              mute_o,
  output logic              refresh_ok_o
);
  logic              active;
  logic [DATA_W-1:0] ch_data [NUM_CH];
  logic              ch_mute [NUM_CH];

  assign active = conceal_applies(mode_i, err_en_i, non_pcm_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    conceal_chan #(.DATA_W(DATA_W), .HOLD_MAX(HOLD_MAX)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (smp_vld_i && smp_chan_i == CH_W'(c)),
      .active_i   (active),
      .par_err_i  (par_err_i),
      .data_i     (smp_data_i),
      .res_data_o (ch_data[c]),
      .res_mute_o (ch_mute[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      mute_o <= 1'b0;
    end else if (smp_vld_i) begin
      data_o <= ch_data[smp_chan_i];
      mute_o <= ch_mute[smp_chan_i];
    end
  end

  refresh_timer #(.FRAMES(FRAMES), .CH_W(CH_W), .LAST_CH(NUM_CH - 1)) u_refresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (smp_vld_i),
    .chan_i    (smp_chan_i),
    .par_err_i (par_err_i),
    .ok_o      (refresh_ok_o)
  );
endmodule

// File: rtl/audio_conceal_checks.sv
module audio_conceal_checks #(
  parameter int DATA_W = 24,
  parameter int CH_W   = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_vld_i,
  input logic [CH_W-1:0]   smp_chan_i,
  input logic [DATA_W-1:0] smp_data_i,
  input logic              par_err_i,
  input logic              non_pcm_i,
  input logic              err_en_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] data_o,
  input logic              mute_o,
  input logic              refresh_ok_o
);
  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> data_o == '0); // R6
  AST_GOOD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && !par_err_i |=> data_o == $past(smp_data_i) && !mute_o); // R7
  AST_MODE_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && (mode_i == 2'b00 || mode_i == 2'b11)
      |=> data_o == $past(smp_data_i) && !mute_o); // R1
  AST_NPCM_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && mode_i == 2'b01 && non_pcm_i
      |=> data_o == $past(smp_data_i) && !mute_o); // R2
  AST_EN_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && !err_en_i |=> data_o == $past(smp_data_i) && !mute_o); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(data_o) && $stable(mute_o)); // R9
  AST_REFRESH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && par_err_i |=> !refresh_ok_o); // R10
endmodule

bind audio_conceal audio_conceal_checks #(.DATA_W(DATA_W), .CH_W(CH_W)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_vld_i    (smp_vld_i),
  .smp_chan_i   (smp_chan_i),
  .smp_data_i   (smp_data_i),
  .par_err_i    (par_err_i),
  .non_pcm_i    (non_pcm_i),
  .err_en_i     (err_en_i),
  .mode_i       (mode_i),
  .data_o       (data_o),
  .mute_o       (mute_o),
  .refresh_ok_o (refresh_ok_o)
);

// File: tb/audio_conceal_bench.sv
module audio_conceal_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic        chan = 1'b0;
  logic [23:0] din = '0;
  logic        perr = 1'b0;
  logic        npcm = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [23:0] dout;
  logic        mute;
  logic        rok;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [23:0] m_held [2];
  int          m_run [2];
  int          m_clean;

  always #5 clk = ~clk;

  audio_conceal u_audio_conceal (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_chan_i(chan),
    .smp_data_i(din), .par_err_i(perr), .non_pcm_i(npcm), .err_en_i(en),
    .mode_i(mode), .data_o(dout), .mute_o(mute), .refresh_ok_o(rok)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int ch, input logic [23:0] d, input bit pe, input bit np,
                      input bit e, input logic [1:0] md, input string force_req);
    bit act;
    logic [23:0] exp_d;
    bit exp_m;
    string req;
    @(negedge clk);
    vld = 1'b1; chan = ch[0]; din = d; perr = pe; npcm = np; en = e; mode = md;
    act = e && ((md == 2'b01 && !np) || md == 2'b10);
    exp_m = 1'b0;
    exp_d = d;
    if (!act) begin
      m_run[ch] = 0;
      if (md == 2'b00 || md == 2'b11) req = "R1";
      else if (!e) req = "R4";
      else req = "R2";
      if (!pe) m_held[ch] = d;
    end else if (pe) begin
      if (m_run[ch] < 9) m_run[ch]++;
      if (m_run[ch] <= 8) begin exp_d = m_held[ch]; req = (md == 2'b10 && np) ? "R3" : "R5"; end
      else begin exp_d = '0; exp_m = 1'b1; req = "R6"; end
    end else begin
      m_run[ch] = 0; m_held[ch] = d; req = "R7";
    end
    if (pe) m_clean = 0;
    else if (ch == 1 && m_clean < 193) m_clean++;
    if (force_req != "") req = force_req;
    @(negedge clk);
    vld = 1'b0; din = ~d; perr = 1'b0;
    chk({req, " data"}, int'(dout), int'(exp_d));
    chk({req, " mute"}, int'(mute), int'(exp_m));
    chk("R10 refresh", int'(rok), int'(m_clean > 192));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_held[0] = '0; m_held[1] = '0; m_run[0] = 0; m_run[1] = 0; m_clean = 0;
    repeat (3) @(negedge clk);
    chk("R11 data", int'(dout), 0);
    chk("R11 mute", int'(mute), 0);
    chk("R11 refresh", int'(rok), 0);
    rst_n = 1'b1;

    // R5: error before any good sample replays zero
    send(0, 24'h123456, 1, 0, 1, 2'b01, "R5");

    for (int md = 0; md < 4; md++)
      for (int e = 0; e < 2; e++)
        for (int np = 0; np < 2; np++) begin
          logic [23:0] base;
          base = 24'(md * 24'h100000 + e * 24'h010000 + np * 24'h001000);
          send(0, base + 24'h1, 0, np[0], e[0], md[1:0], "");
          send(1, base + 24'h2, 0, np[0], e[0], md[1:0], "");
          for (int k = 0; k < 10; k++) begin
            send(0, base + 24'h100 + 24'(k), 1, np[0], e[0], md[1:0], "");
            send(1, base + 24'h200 + 24'(k), 0, np[0], e[0], md[1:0], "R8");
          end
          send(1, base + 24'h300, 1, np[0], e[0], md[1:0], "");
          send(0, base + 24'h400, 0, np[0], e[0], md[1:0], "R7");
          for (int k = 0; k < 9; k++)
            send(0, base + 24'h500 + 24'(k), 1, np[0], e[0], md[1:0], "");
          send(0, base + 24'h600, 0, np[0], e[0], md[1:0], "");
          send(1, base + 24'h700, 0, np[0], e[0], md[1:0], "");
          repeat (2) @(negedge clk);
          chk("R9 idle data", int'(dout), int'(base + 24'h700));
          chk("R9 idle mute", int'(mute), 0);
        end

    // R10: boundary at 192 and 193 clean frames
    send(0, 24'h0abcde, 1, 0, 0, 2'b00, "R1");
    for (int f = 0; f < 193; f++) begin
      send(0, 24'(f), 0, 0, 1, 2'b01, "");
      send(1, 24'(f + 1000), 0, 0, 1, 2'b01, "");
      if (f == 191) chk("R10 at 192 frames", int'(rok), 0);
      if (f == 192) chk("R10 at 193 frames", int'(rok), 1);
    end
    send(0, 24'h55aa55, 1, 0, 0, 2'b00, "R1");
    chk("R10 drop on error", int'(rok), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule